// File: doc/BRIEF.md
# VPW Bus Symbol Receiver

This block listens to the receive line of a variable-pulse-width serial bus. The line is either passive (idle) or active (driven), and each change of level ends a symbol. The block measures how long each level lasted in units of an external microsecond tick. The length and the level together give a data bit, a start-of-frame, an end-of-data or an end-of-frame. A too-short level counts as noise. A driven level that lasts too long counts as a break.

Data bits are collected most-significant first into bytes. Each finished byte goes into a two-entry buffer that a host drains one byte at a time with a read strobe. A status byte records a completed message, a buffer overrun and a break. Its bits stay set until the host clears them by writing ones. An interrupt pulse marks every overrun. The receiver does not check CRC, take part in arbitration or build in-frame responses.

Top module: `vpw_rx`

## Requirements
- R1: After reset `status_o` is 00h, `rd_valid_o` is 0 and `irq_o` is 0.
- R2: Pulse width is the number of clock cycles with `tick_i` high while the line holds one level. Cycles with `tick_i` low do not add to the width.
- R3: A passive level (`rx_i` = 0) lasting 34 to 95 ticks decodes as bit 0. One lasting 96 to 162 ticks decodes as bit 1.
- R4: An active level (`rx_i` = 1) lasting 34 to 95 ticks decodes as bit 1. One lasting 96 to 162 ticks decodes as bit 0.
- R5: A level of either polarity shorter than 34 ticks yields no bit. The symbols around it decode normally.
- R6: An active level of 163 to 238 ticks is a start-of-frame. It opens a message and discards any partly assembled byte.
- R7: Data symbols that arrive while no message is open are ignored: before the first start-of-frame, and after end-of-data, end-of-frame or a break.
- R8: Bits are shifted in most-significant first. Every eighth bit of a message places the byte in a two-entry buffer. `rd_valid_o` is high while the buffer holds a byte, and `rd_data_o` shows the oldest byte. A one-cycle `rd_i` pulse removes that byte.
- R9: A byte that completes while both buffer entries are unread is dropped. It sets `status_o[1]` (overrun) and gives a one-cycle pulse on `irq_o`. The two stored bytes are kept.
- R10: A passive level reaching 163 ticks inside a message is end-of-data. It sets `status_o[0]` (message received), drops any partial byte and closes the message.
- R11: An active level reaching 239 ticks inside a message is a break. It sets `status_o[2]`, drops the partial byte and closes the message. A passive level of 239 ticks or more is end-of-frame/idle.
- R12: Writing a 1 to a bit of `stat_clr_i` for one cycle clears that `status_o` bit. Bits written 0 keep their value. A status event in the same cycle overrides the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Bus receive line, 1 = active |
| tick_i | input | 1 | One-cycle strobe per microsecond |
| rd_i | input | 1 | Removes the oldest buffered byte |
| stat_clr_i | input | 8 | Write-one-to-clear for status bits |
| rd_data_o | output | 8 | Oldest buffered byte |
| rd_valid_o | output | 1 | Buffer holds at least one byte |
| status_o | output | 8 | bit0 message received, bit1 overrun, bit2 break |
| irq_o | output | 1 | One-cycle pulse on overrun |

## Verification
The hardest cases to reach from the ports are the ones that depend on symbol alternation. A rejected noise pulse still flips the line level, so every symbol after it decodes with the opposite polarity. A break can only follow an active level. The stimulus therefore builds frames level by level and tracks the current line level itself. Each bit's width is chosen from that level, so the bench can place a noise pulse, a second start-of-frame or a long active level exactly where a message is part-way through a byte. Overrun needs three bytes inside one message with no reads in between. The decode boundaries 34, 95, 96 and 162 are exercised by the table of frames. A run with `tick_i` high only every other cycle shows that only tick cycles are counted.

// File: rtl/vpw_rx_pkg.sv
package vpw_rx_pkg;
  typedef enum logic [2:0] {
    SYM_NONE,
    SYM_BIT0,
    SYM_BIT1,
    SYM_SOF,
    SYM_EOD,
    SYM_EOF,
    SYM_BRK
  } sym_e;

  localparam int unsigned ST_MSG = 0;
  localparam int unsigned ST_OVR = 1;
  localparam int unsigned ST_BRK = 2;
endpackage

// File: rtl/vpw_rx_sync.sv
module vpw_rx_sync #(
  parameter int unsigned STAGES   = 2,
  parameter logic        IDLE_LVL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_i,
  output logic lvl_o,
  output logic prev_o,
  output logic edge_o
);
  logic [STAGES-1:0] chain_q;
  logic              lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= {STAGES{IDLE_LVL}};
      lvl_q   <= IDLE_LVL;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], rx_i};
      lvl_q   <= chain_q[STAGES-1];
    end
  end

  assign lvl_o  = chain_q[STAGES-1];
  assign prev_o = lvl_q;
  assign edge_o = chain_q[STAGES-1] ^ lvl_q;
endmodule

// File: rtl/vpw_rx_timer.sv
module vpw_rx_timer
  import vpw_rx_pkg::*;
#(
  parameter int unsigned CNT_W   = 8,
  parameter int unsigned T_MIN   = 34,
  parameter int unsigned T_SHORT = 96,
  parameter int unsigned T_LONG  = 163,
  parameter int unsigned T_END   = 239,
  parameter logic        ACT_LVL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic lvl_i,
  input  logic prev_i,
  input  logic edge_i,
  output sym_e sym_o
);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] TH_MIN   = CNT_W'(T_MIN);
  localparam logic [CNT_W-1:0] TH_SHORT = CNT_W'(T_SHORT);
  localparam logic [CNT_W-1:0] TH_LONG  = CNT_W'(T_LONG);
  localparam logic [CNT_W-1:0] TH_END   = CNT_W'(T_END);
  localparam logic [CNT_W-1:0] PRE_EOD  = CNT_W'(T_LONG - 1);
  localparam logic [CNT_W-1:0] PRE_END  = CNT_W'(T_END - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             prev_act, now_act;

  assign prev_act = (prev_i == ACT_LVL);
  assign now_act  = (lvl_i == ACT_LVL);

  // width of the level now in progress, counted in ticks
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_q <= '0;
    else if (edge_i)                    cnt_q <= {{(CNT_W-1){1'b0}}, tick_i};
    else if (tick_i && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  always_comb begin
    sym_o = SYM_NONE;
    if (edge_i) begin
      // classify the level that just ended
      if (cnt_q < TH_MIN)        sym_o = SYM_NONE;
      else if (cnt_q < TH_SHORT) sym_o = prev_act ? SYM_BIT1 : SYM_BIT0;
      else if (cnt_q < TH_LONG)  sym_o = prev_act ? SYM_BIT0 : SYM_BIT1;
      else if (cnt_q < TH_END)   sym_o = prev_act ? SYM_SOF : SYM_NONE;
      else                       sym_o = SYM_NONE;
    end else if (tick_i) begin
      // long levels are reported as the threshold is crossed
      if (cnt_q == PRE_EOD && !now_act) sym_o = SYM_EOD;
      else if (cnt_q == PRE_END)        sym_o = now_act ? SYM_BRK : SYM_EOF;
    end
  end
endmodule

// File: rtl/vpw_rx_frame.sv
module vpw_rx_frame
  import vpw_rx_pkg::*;
#(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  sym_e              sym_i,
  output logic              push_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic              msg_o,
  output logic              brk_o
);
  localparam int unsigned      BC_W = $clog2(BYTE_W);
  localparam logic [BC_W-1:0]  LAST = BC_W'(BYTE_W - 1);

  logic              in_frame_q;
  logic [BYTE_W-2:0] sh_q;
  logic [BC_W-1:0]   bcnt_q;
  logic              bit_val;

  assign bit_val = (sym_i == SYM_BIT1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_frame_q <= 1'b0;
      sh_q       <= '0;
      bcnt_q     <= '0;
      push_o     <= 1'b0;
      byte_o     <= '0;
      msg_o      <= 1'b0;
      brk_o      <= 1'b0;
    end else begin
      push_o <= 1'b0;
      msg_o  <= 1'b0;
      brk_o  <= 1'b0;
      unique case (sym_i)
        SYM_SOF: begin
          in_frame_q <= 1'b1;
          bcnt_q     <= '0;
        end
        SYM_BIT0, SYM_BIT1: begin
          if (in_frame_q) begin
            if (bcnt_q == LAST) begin
              push_o <= 1'b1;
              byte_o <= {sh_q, bit_val};
              bcnt_q <= '0;
            end else begin
              sh_q   <= {sh_q[BYTE_W-3:0], bit_val};
              bcnt_q <= bcnt_q + 1'b1;
            end
          end
        end
        SYM_EOD: begin
          if (in_frame_q) msg_o <= 1'b1;
          in_frame_q <= 1'b0;
          bcnt_q     <= '0;
        end
        SYM_BRK: begin
          if (in_frame_q) brk_o <= 1'b1;
          in_frame_q <= 1'b0;
          bcnt_q     <= '0;
        end
        SYM_EOF: begin
          in_frame_q <= 1'b0;
          bcnt_q     <= '0;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/vpw_rx_fifo.sv
module vpw_rx_fifo #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] data_o,
  output logic         valid_o,
  output logic         ovr_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;
  logic             pop_ok, push_ok;

  assign valid_o = (cnt_q != '0);
  assign pop_ok  = pop_i && valid_o;
  assign push_ok = push_i && ((cnt_q != CNT_FULL) || pop_ok);
  assign ovr_o   = push_i && !push_ok;
  assign data_o  = mem_q[rd_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      if (push_ok) begin
        mem_q[wr_q] <= data_i;
        wr_q        <= (wr_q == PTR_LAST) ? '0 : wr_q + 1'b1;
      end
      if (pop_ok) rd_q <= (rd_q == PTR_LAST) ? '0 : rd_q + 1'b1;
      if (push_ok && !pop_ok)      cnt_q <= cnt_q + 1'b1;
      else if (pop_ok && !push_ok) cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/vpw_rx.sv
module vpw_rx
  import vpw_rx_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned T_MIN       = 34,
  parameter int unsigned T_SHORT     = 96,
  parameter int unsigned T_LONG      = 163,
  parameter int unsigned T_END       = 239,
  parameter int unsigned BUF_DEPTH   = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rx_i,
  input  logic       tick_i,
  input  logic       rd_i,
  input  logic [7:0] stat_clr_i,
  output logic [7:0] rd_data_o,
  output logic       rd_valid_o,
  output logic [7:0] status_o,
  output logic       irq_o
);
  logic       lvl, prev_lvl, lvl_edge;
  sym_e       sym;
  logic       byte_push, msg_evt, brk_evt, ovr_evt;
  logic [7:0] byte_val;
  logic [7:0] set_vec;
  logic [7:0] status_q;
  logic       irq_q;

  vpw_rx_sync #(.STAGES(SYNC_STAGES), .IDLE_LVL(1'b0)) i_sync (
    .clk_i, .rst_ni, .rx_i,
    .lvl_o(lvl), .prev_o(prev_lvl), .edge_o(lvl_edge)
  );

  vpw_rx_timer #(
    .CNT_W(CNT_W), .T_MIN(T_MIN), .T_SHORT(T_SHORT),
    .T_LONG(T_LONG), .T_END(T_END), .ACT_LVL(1'b1)
  ) i_timer (
    .clk_i, .rst_ni, .tick_i,
    .lvl_i(lvl), .prev_i(prev_lvl), .edge_i(lvl_edge), .sym_o(sym)
  );

  vpw_rx_frame #(.BYTE_W(8)) i_frame (
    .clk_i, .rst_ni, .sym_i(sym),
    .push_o(byte_push), .byte_o(byte_val), .msg_o(msg_evt), .brk_o(brk_evt)
  );

  vpw_rx_fifo #(.W(8), .DEPTH(BUF_DEPTH)) i_fifo (
    .clk_i, .rst_ni, .push_i(byte_push), .data_i(byte_val), .pop_i(rd_i),
    .data_o(rd_data_o), .valid_o(rd_valid_o), .ovr_o(ovr_evt)
  );

  always_comb begin
    set_vec         = '0;
    set_vec[ST_MSG] = msg_evt;
    set_vec[ST_OVR] = ovr_evt;
    set_vec[ST_BRK] = brk_evt;
  end

  // events win over a simultaneous clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= '0;
      irq_q    <= 1'b0;
    end else begin
      status_q <= (status_q & ~stat_clr_i) | set_vec;
      irq_q    <= ovr_evt;
    end
  end

  assign status_o = status_q;
  assign irq_o    = irq_q;
endmodule

// File: rtl/vpw_rx_chk.sv
module vpw_rx_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       rd_i,
  input logic [7:0] stat_clr_i,
  input logic [7:0] rd_data_o,
  input logic       rd_valid_o,
  input logic [7:0] status_o,
  input logic       irq_o,
  input logic       push_i
);
  // R9
  ovr_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> status_o[1]);

  // R9
  irq_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

  // R8
  head_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_o && !rd_i) |=> (rd_valid_o && $stable(rd_data_o)));

  // R8
  valid_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_valid_o) |-> $past(push_i));

  // R12
  sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(status_o) & ~status_o & ~$past(stat_clr_i)) == 8'h00));
endmodule

bind vpw_rx vpw_rx_chk i_vpw_rx_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .rd_i(rd_i), .stat_clr_i(stat_clr_i),
  .rd_data_o(rd_data_o), .rd_valid_o(rd_valid_o), .status_o(status_o),
  .irq_o(irq_o), .push_i(byte_push)
);

// File: tb/test_vpw_rx.sv
module test_vpw_rx;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       rx_i = 1'b0;
  logic       tick_i = 1'b1;
  logic       rd_i = 1'b0;
  logic [7:0] stat_clr_i = 8'h00;
  logic [7:0] rd_data_o;
  logic       rd_valid_o;
  logic [7:0] status_o;
  logic       irq_o;

  int n_chk = 0;
  int n_bad = 0;
  int irq_cnt = 0;
  int tick_div = 1;
  int tick_ph = 0;
  logic cur_lvl = 1'b0;

  always #5 clk_i = ~clk_i;

  vpw_rx i_vpw_rx (
    .clk_i, .rst_ni, .rx_i, .tick_i, .rd_i, .stat_clr_i,
    .rd_data_o, .rd_valid_o, .status_o, .irq_o
  );

  always @(posedge clk_i) if (irq_o) irq_cnt++;

  initial forever begin
    @(negedge clk_i);
    tick_ph = (tick_ph + 1) % tick_div;
    tick_i  = (tick_ph == 0);
  end

  // data, short width, long width (ticks)
  localparam logic [23:0] VEC [6] = '{
    {8'hA5, 8'd64, 8'd128},
    {8'h3C, 8'd34, 8'd96},
    {8'hFF, 8'd95, 8'd162},
    {8'h00, 8'd34, 8'd162},
    {8'h5A, 8'd95, 8'd96},
    {8'h81, 8'd50, 8'd140}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic sym(input logic l, input int w);
    rx_i    = l;
    cur_lvl = l;
    repeat (w * tick_div) @(negedge clk_i);
  endtask

  task automatic send_bit(input logic b, input int sw, input int lw);
    logic l;
    l = ~cur_lvl;
    if (l) sym(l, b ? sw : lw);
    else   sym(l, b ? lw : sw);
  endtask

  task automatic send_byte(input logic [7:0] d, input int sw, input int lw);
    for (int i = 7; i >= 0; i--) send_bit(d[i], sw, lw);
  endtask

  task automatic sof();
    sym(1'b1, 200);
  endtask

  task automatic idle();
    sym(1'b0, 300);
  endtask

  task automatic pop();
    rd_i = 1'b1;
    @(negedge clk_i);
    rd_i = 1'b0;
    @(negedge clk_i);
  endtask

  task automatic clr(input logic [7:0] m);
    stat_clr_i = m;
    @(negedge clk_i);
    stat_clr_i = 8'h00;
    @(negedge clk_i);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk_i);
    // R1
    check("R1 status", status_o, 8'h00);
    check("R1 valid", rd_valid_o, 0);
    check("R1 irq", irq_o, 0);
    rst_ni = 1'b1;
    idle();
    check("R1 status idle", status_o, 8'h00);

    // R3 R4 R8 R10: table of frames at window boundaries
    for (int v = 0; v < 6; v++) begin
      sof();
      send_byte(VEC[v][23:16], int'(VEC[v][15:8]), int'(VEC[v][7:0]));
      sym(1'b0, 100);
      check("R10 no msg before eod", status_o[0], 0);
      check("R8 valid", rd_valid_o, 1);
      check("R3 R4 byte", rd_data_o, VEC[v][23:16]);
      sym(1'b0, 200);
      check("R10 msg", status_o[0], 1);
      pop();
      check("R8 empty after pop", rd_valid_o, 0);
      clr(8'hFF);
    end

    // R7: data with no start-of-frame
    send_byte(8'h55, 64, 128);
    send_byte(8'hC6, 64, 128);
    idle();
    check("R7 no byte", rd_valid_o, 0);
    check("R7 no status", status_o, 8'h00);

    // R5: noise pulses of both polarities inside a message
    sof();
    sym(1'b0, 20);
    send_byte(8'hC3, 64, 128);
    sym(1'b1, 33);
    idle();
    check("R5 byte", rd_data_o, 8'hC3);
    check("R5 msg", status_o[0], 1);
    pop();
    check("R5 single byte", rd_valid_o, 0);
    clr(8'hFF);

    // R6: second start-of-frame drops partial byte
    sof();
    send_bit(1, 64, 128); send_bit(1, 64, 128); send_bit(0, 64, 128);
    send_bit(1, 64, 128); send_bit(1, 64, 128);
    sof();
    send_byte(8'h96, 64, 128);
    idle();
    check("R6 byte", rd_data_o, 8'h96);
    pop();
    check("R6 single byte", rd_valid_o, 0);
    clr(8'hFF);

    // R10: partial bits before end-of-data are dropped
    sof();
    send_byte(8'h12, 64, 128);
    send_bit(1, 64, 128); send_bit(0, 64, 128);
    idle();
    check("R10 byte", rd_data_o, 8'h12);
    pop();
    check("R10 partial dropped", rd_valid_o, 0);
    check("R10 msg partial", status_o[0], 1);
    clr(8'hFF);

    // R9 R12: three bytes, no reads
    sof();
    send_byte(8'h11, 64, 128);
    send_byte(8'h22, 64, 128);
    send_byte(8'h33, 64, 128);
    idle();
    check("R9 overrun", status_o[1], 1);
    check("R9 irq count", irq_cnt, 1);
    check("R9 first", rd_data_o, 8'h11);
    pop();
    check("R9 second", rd_data_o, 8'h22);
    pop();
    check("R9 third dropped", rd_valid_o, 0);
    clr(8'h02);
    check("R12 overrun cleared", status_o[1], 0);
    check("R12 msg kept", status_o[0], 1);
    clr(8'hFF);
    check("R12 all cleared", status_o, 8'h00);

    // R8: two unread bytes give no overrun
    sof();
    send_byte(8'hE7, 64, 128);
    send_byte(8'h09, 64, 128);
    idle();
    check("R8 no overrun", status_o[1], 0);
    check("R8 oldest first", rd_data_o, 8'hE7);
    pop();
    check("R8 second", rd_data_o, 8'h09);
    pop();
    clr(8'hFF);

    // R11: break aborts, then R7 data ignored, then fresh frame
    sof();
    send_bit(1, 64, 128); send_bit(0, 64, 128); send_bit(1, 64, 128);
    sym(1'b1, 260);
    idle();
    check("R11 break", status_o[2], 1);
    check("R11 no msg", status_o[0], 0);
    check("R11 no byte", rd_valid_o, 0);
    send_byte(8'hAA, 64, 128);
    idle();
    check("R7 after break", rd_valid_o, 0);
    clr(8'hFF);
    sof();
    send_byte(8'h6B, 64, 128);
    idle();
    check("R11 recover", rd_data_o, 8'h6B);
    pop();
    clr(8'hFF);

    // R2: tick every other cycle
    tick_div = 2;
    idle();
    sof();
    send_byte(8'h4D, 64, 128);
    idle();
    check("R2 byte", rd_data_o, 8'h4D);
    check("R2 msg", status_o[0], 1);
    pop();
    tick_div = 1;

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule